// File: doc/BRIEF.md
# Five-Stage In-Order Integer Pipeline

This block is a 32-bit processor core split into five stages: instruction fetch, decode with register read, execute, memory access and register write-back. Each stage is separated from the next by a pipeline register. One instruction enters per clock and, in steady state, one leaves per clock. The instruction set is small: word load, word store, equality branch, and five register-to-register operations (add, subtract, and, or, signed set-less-than). Any other encoding is executed as a no-op.

Instruction and data storage are small word arrays inside the block. A preload port fills them while reset is held. The core has no forwarding, no interlock and no flush, so hazards can be seen in the results. A taken branch only redirects fetch at the end of its memory stage, which leaves three delay slots that always execute. A register result can first be read by the instruction fetched four slots after its producer. Every register write is performed in stage 5; for register-to-register operations the memory stage only passes the result along. Debug outputs show the fetch address and each retiring register write, so the program's effect can be followed cycle by cycle.

Top module: `pipe5_core`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, the fetch address is 0. No write-back is reported in the first four cycles after reset falls.
- R2: If no taken branch redirects it, the fetch address grows by 4 every cycle. The instruction word is read from word index address[IMEM_AW+1:2].
- R3: A register-to-register operation has opcode 0 and writes rd, with result a+b, a-b, a&b or a|b for funct 0x20, 0x22, 0x24 or 0x25. For funct 0x2A it writes 1 when a is less than b as signed numbers, and 0 otherwise. The write is reported four cycles after the instruction's fetch cycle.
- R4: A load (opcode 0x23) reads the data word at index (rs + sign-extended imm)[DMEM_AW+1:2] and writes it to rt. Instruction fields are opcode 31:26, rs 25:21, rt 20:16, rd 15:11, funct 5:0 and imm 15:0.
- R5: A store (opcode 0x2B) writes rt's value to the data word addressed as in a load. Any later load reads the stored value. A store reports no write-back.
- R6: A branch (opcode 0x04) whose two register operands are equal sets the fetch address to the branch's address + 4 + (sign-extended imm << 2). This takes effect in the fourth cycle after the branch's fetch. The three instructions fetched in between always execute.
- R7: There is no bypass. An instruction reads the register values written by instructions fetched four or more slots earlier. Instructions fetched one to three slots later read the old values.
- R8: Register 0 reads as zero. A write aimed at it is dropped, and no write-back is reported for it.
- R9: Any other opcode, or opcode 0 with any other funct, writes no register, stores nothing and does not branch.
- R10: While reset is high, a preload write with target 0 stores a word into instruction memory, and with target 1 into data memory, at the given word index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| loadEn | input | 1 | Preload write strobe |
| loadToData | input | 1 | Preload target: 0 instruction memory, 1 data memory |
| loadAddr | input | LOAD_AW | Preload word index |
| loadWord | input | 32 | Preload data word |
| dbgPc | output | 32 | Current fetch address |
| dbgWbEn | output | 1 | A register write is retiring this cycle |
| dbgWbReg | output | 5 | Destination register of the retiring write |
| dbgWbData | output | 32 | Value being written |

## Verification
The bench builds the core with 64-word instruction and data memories (IMEM_AW = DMEM_AW = 6). This lets one bench image fill instruction memory completely, with no-op words after the program. With these sizes, random load and store addresses and backward branches wrap around inside the arrays, so fetch loops and address aliasing are exercised alongside the directed sequences. The directed programs cover load-use visibility across the three blind slots, the delay slots after a taken branch, signed set-less-than on a negative value, writes to register 0, and store-then-load ordering.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;
  localparam int XLEN = 32;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
  } aluOp_e;

  // Strobes produced in decode and carried down the pipeline
  typedef struct packed {
    logic   regWrite;
    logic   memToReg;
    logic   memWrite;
    logic   branch;
    logic   aluSrc;
    logic   regDst;
    aluOp_e aluOp;
  } ctrl_t;

  localparam ctrl_t CTRL_NOP = '{regWrite: 1'b0, memToReg: 1'b0, memWrite: 1'b0,
                                 branch: 1'b0, aluSrc: 1'b0, regDst: 1'b0,
                                 aluOp: ALU_ADD};
endpackage

// File: rtl/pipe5_ctrl.sv
module pipe5_ctrl
  import pipe5_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = CTRL_NOP;
    unique case (opcode)
      OP_LOAD: begin
        ctrl.regWrite = 1'b1;
        ctrl.memToReg = 1'b1;
        ctrl.aluSrc   = 1'b1;
      end
      OP_STORE: begin
        ctrl.memWrite = 1'b1;
        ctrl.aluSrc   = 1'b1;
      end
      OP_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.aluOp  = ALU_SUB;
      end
      OP_RTYPE: begin
        ctrl.regDst = 1'b1;
        ctrl.regWrite = 1'b1;
        unique case (funct)
          FN_ADD:  ctrl.aluOp = ALU_ADD;
          FN_SUB:  ctrl.aluOp = ALU_SUB;
          FN_AND:  ctrl.aluOp = ALU_AND;
          FN_OR:   ctrl.aluOp = ALU_OR;
          FN_SLT:  ctrl.aluOp = ALU_SLT;
          default: ctrl = CTRL_NOP;
        endcase
      end
      default: ctrl = CTRL_NOP;
    endcase
  end
endmodule

// File: rtl/pipe5_regfile.sv
module pipe5_regfile #(
  parameter int WIDTH = 32,
  parameter int NREGS = 32,
  localparam int RAW = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [RAW-1:0]   rdAddrA,
  input  logic [RAW-1:0]   rdAddrB,
  output logic [WIDTH-1:0] rdDataA,
  output logic [WIDTH-1:0] rdDataB,
  input  logic             wrEn,
  input  logic [RAW-1:0]   wrAddr,
  input  logic [WIDTH-1:0] wrData
);
  logic [WIDTH-1:0] regs [NREGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (wrEn && wrAddr != '0) begin
      regs[wrAddr] <= wrData;
    end
  end

  // No write-to-read bypass: a same-cycle write is seen only next cycle
  assign rdDataA = (rdAddrA == '0) ? '0 : regs[rdAddrA];
  assign rdDataB = (rdAddrB == '0) ? '0 : regs[rdAddrB];
endmodule

// File: rtl/pipe5_datapath.sv
module pipe5_datapath
  import pipe5_pkg::*;
#(
  parameter int IMEM_AW = 6,
  parameter int DMEM_AW = 6,
  parameter int LOAD_AW = 6,
  localparam int IMEM_WORDS = 1 << IMEM_AW,
  localparam int DMEM_WORDS = 1 << DMEM_AW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               loadEn,
  input  logic               loadToData,
  input  logic [LOAD_AW-1:0] loadAddr,
  input  logic [XLEN-1:0]    loadWord,
  output logic [5:0]         idOpcode,
  output logic [5:0]         idFunct,
  input  ctrl_t              idCtrl,
  output logic [XLEN-1:0]    dbgPc,
  output logic               dbgWbEn,
  output logic [4:0]         dbgWbReg,
  output logic [XLEN-1:0]    dbgWbData,
  output logic               branchTaken,
  output logic [XLEN-1:0]    branchTarget
);
  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  // ---------------- fetch ----------------
  logic [XLEN-1:0] pc;
  logic [XLEN-1:0] fetchWord;
  logic            ifidValid;
  logic [XLEN-1:0] ifidInstr, ifidPc4;

  assign fetchWord = imem[pc[IMEM_AW+1:2]];

  always_ff @(posedge clk) begin
    if (loadEn && !loadToData) imem[loadAddr[IMEM_AW-1:0]] <= loadWord;
  end

  always_ff @(posedge clk) begin
    if (rst)              pc <= '0;
    else if (branchTaken) pc <= branchTarget;
    else                  pc <= pc + 32'd4;
  end

  always_ff @(posedge clk) begin
    if (rst) ifidValid <= 1'b0;
    else     ifidValid <= 1'b1;
    ifidInstr <= fetchWord;
    ifidPc4   <= pc + 32'd4;
  end

  // ---------------- decode ----------------
  logic [4:0]      idRs, idRt, idRd;
  logic [XLEN-1:0] idA, idB, idImm;
  logic            wbWrite;
  logic [4:0]      wbReg;
  logic [XLEN-1:0] wbData;

  assign idOpcode = ifidInstr[31:26];
  assign idFunct  = ifidInstr[5:0];
  assign idRs     = ifidInstr[25:21];
  assign idRt     = ifidInstr[20:16];
  assign idRd     = ifidInstr[15:11];
  assign idImm    = {{(XLEN-16){ifidInstr[15]}}, ifidInstr[15:0]};

  pipe5_regfile #(.WIDTH(XLEN), .NREGS(32)) u_regs (
    .clk(clk), .rst(rst),
    .rdAddrA(idRs), .rdAddrB(idRt),
    .rdDataA(idA), .rdDataB(idB),
    .wrEn(wbWrite), .wrAddr(wbReg), .wrData(wbData)
  );

  logic            idexValid;
  ctrl_t           idexCtrl;
  logic [XLEN-1:0] idexA, idexB, idexImm, idexPc4;
  logic [4:0]      idexRt, idexRd;

  always_ff @(posedge clk) begin
    if (rst) idexValid <= 1'b0;
    else     idexValid <= ifidValid;
    idexCtrl <= idCtrl;
    idexA    <= idA;
    idexB    <= idB;
    idexImm  <= idImm;
    idexPc4  <= ifidPc4;
    idexRt   <= idRt;
    idexRd   <= idRd;
  end

  // ---------------- execute ----------------
  logic [XLEN-1:0] exOpB, exAlu, exTarget;
  logic [4:0]      exDest;

  assign exOpB    = idexCtrl.aluSrc ? idexImm : idexB;
  assign exDest   = idexCtrl.regDst ? idexRd : idexRt;
  assign exTarget = idexPc4 + {idexImm[XLEN-3:0], 2'b00};

  always_comb begin
    unique case (idexCtrl.aluOp)
      ALU_ADD: exAlu = idexA + exOpB;
      ALU_SUB: exAlu = idexA - exOpB;
      ALU_AND: exAlu = idexA & exOpB;
      ALU_OR:  exAlu = idexA | exOpB;
      ALU_SLT: exAlu = {{(XLEN-1){1'b0}}, $signed(idexA) < $signed(exOpB)};
      default: exAlu = idexA + exOpB;
    endcase
  end

  logic            exmemValid, exmemZero;
  ctrl_t           exmemCtrl;
  logic [XLEN-1:0] exmemAlu, exmemStore, exmemTarget;
  logic [4:0]      exmemDest;

  always_ff @(posedge clk) begin
    if (rst) exmemValid <= 1'b0;
    else     exmemValid <= idexValid;
    exmemCtrl   <= idexCtrl;
    exmemAlu    <= exAlu;
    exmemZero   <= (exAlu == '0);
    exmemStore  <= idexB;
    exmemTarget <= exTarget;
    exmemDest   <= exDest;
  end

  // ---------------- memory ----------------
  logic [XLEN-1:0] memRead;
  logic [DMEM_AW-1:0] memIdx;

  assign memIdx       = exmemAlu[DMEM_AW+1:2];
  assign memRead      = dmem[memIdx];
  assign branchTaken  = exmemValid && exmemCtrl.branch && exmemZero;
  assign branchTarget = exmemTarget;

  always_ff @(posedge clk) begin
    if (loadEn && loadToData)
      dmem[loadAddr[DMEM_AW-1:0]] <= loadWord;
    else if (exmemValid && exmemCtrl.memWrite)
      dmem[memIdx] <= exmemStore;
  end

  logic            memwbValid, memwbRegWrite, memwbMemToReg;
  logic [XLEN-1:0] memwbRead, memwbAlu;
  logic [4:0]      memwbDest;

  always_ff @(posedge clk) begin
    if (rst) memwbValid <= 1'b0;
    else     memwbValid <= exmemValid;
    memwbRegWrite <= exmemCtrl.regWrite;
    memwbMemToReg <= exmemCtrl.memToReg;
    memwbRead     <= memRead;
    memwbAlu      <= exmemAlu;
    memwbDest     <= exmemDest;
  end

  // ---------------- write-back ----------------
  assign wbWrite = memwbValid && memwbRegWrite && (memwbDest != 5'd0);
  assign wbReg   = memwbDest;
  assign wbData  = memwbMemToReg ? memwbRead : memwbAlu;

  assign dbgPc     = pc;
  assign dbgWbEn   = wbWrite;
  assign dbgWbReg  = wbReg;
  assign dbgWbData = wbData;
endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
  import pipe5_pkg::*;
#(
  parameter int IMEM_AW = 6,
  parameter int DMEM_AW = 6,
  localparam int LOAD_AW = (IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               loadEn,
  input  logic               loadToData,
  input  logic [LOAD_AW-1:0] loadAddr,
  input  logic [31:0]        loadWord,
  output logic [31:0]        dbgPc,
  output logic               dbgWbEn,
  output logic [4:0]         dbgWbReg,
  output logic [31:0]        dbgWbData
);
  logic [5:0]  idOpcode, idFunct;
  ctrl_t       idCtrl;
  logic        branchTaken;
  logic [31:0] branchTarget;

  pipe5_ctrl u_ctrl (
    .opcode(idOpcode), .funct(idFunct), .ctrl(idCtrl)
  );

  pipe5_datapath #(.IMEM_AW(IMEM_AW), .DMEM_AW(DMEM_AW), .LOAD_AW(LOAD_AW)) u_dp (
    .clk(clk), .rst(rst),
    .loadEn(loadEn), .loadToData(loadToData), .loadAddr(loadAddr), .loadWord(loadWord),
    .idOpcode(idOpcode), .idFunct(idFunct), .idCtrl(idCtrl),
    .dbgPc(dbgPc), .dbgWbEn(dbgWbEn), .dbgWbReg(dbgWbReg), .dbgWbData(dbgWbData),
    .branchTaken(branchTaken), .branchTarget(branchTarget)
  );
endmodule

// File: rtl/pipe5_checker.sv
module pipe5_checker (
  input logic        clk,
  input logic        rst,
  input logic [31:0] dbgPc,
  input logic        dbgWbEn,
  input logic [4:0]  dbgWbReg,
  input logic        branchTaken,
  input logic [31:0] branchTarget
);
  // R1: first cycle out of reset fetches address 0 and retires nothing
  a_r1_reset_start: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (dbgPc == 32'd0 && !dbgWbEn));

  // R2: sequential fetch when no redirect happened on the previous edge
  a_r2_seq_fetch: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(branchTaken)) |-> dbgPc == $past(dbgPc) + 32'd4);

  // R6: a taken branch loads its target into the fetch address
  a_r6_redirect: assert property (@(posedge clk) disable iff (rst)
    branchTaken |=> dbgPc == $past(branchTarget));

  // R6: branch targets stay word aligned
  a_r6_aligned: assert property (@(posedge clk) disable iff (rst)
    branchTaken |-> branchTarget[1:0] == 2'b00);

  // R8: register 0 is never reported as written
  a_r8_no_zero_write: assert property (@(posedge clk) disable iff (rst)
    dbgWbEn |-> dbgWbReg != 5'd0);
endmodule

bind pipe5_core pipe5_checker u_chk (
  .clk(clk), .rst(rst), .dbgPc(dbgPc), .dbgWbEn(dbgWbEn), .dbgWbReg(dbgWbReg),
  .branchTaken(branchTaken), .branchTarget(branchTarget)
);

// File: tb/pipe5_core_bench.sv
module pipe5_core_bench;
  localparam int IAW = 6;
  localparam int DAW = 6;
  localparam int IW = 1 << IAW;
  localparam int DW = 1 << DAW;
  localparam int LAW = 6;
  localparam int MAXP = 200;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1, loadEn = 1'b0, loadToData = 1'b0;
  logic [LAW-1:0] loadAddr = '0;
  logic [31:0] loadWord = '0;
  logic [31:0] dbgPc, dbgWbData;
  logic dbgWbEn;
  logic [4:0] dbgWbReg;

  pipe5_core #(.IMEM_AW(IAW), .DMEM_AW(DAW)) u_pipe5_core (
    .clk(clk), .rst(rst), .loadEn(loadEn), .loadToData(loadToData),
    .loadAddr(loadAddr), .loadWord(loadWord),
    .dbgPc(dbgPc), .dbgWbEn(dbgWbEn), .dbgWbReg(dbgWbReg), .dbgWbData(dbgWbData)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [31:0] imemImg [IW];
  logic [31:0] dmemImg [DW];
  logic [31:0] pcExp [MAXP];
  logic        wbEnExp [MAXP];
  logic [4:0]  wbRegExp [MAXP];
  logic [31:0] wbDataExp [MAXP];
  string       tagExp [MAXP];
  string       pcTag [MAXP];
  logic [31:0] mreg [32];
  logic [31:0] mmem [DW];
  logic        redirV [MAXP];
  logic [31:0] redirPc [MAXP];

  function automatic logic [31:0] encR(logic [5:0] fn, logic [4:0] rs, logic [4:0] rt, logic [4:0] rd);
    return {6'h00, rs, rt, rd, 5'd0, fn};
  endfunction

  function automatic logic [31:0] encI(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Reference model from the requirements: slot s reads registers after the
  // writes of slots <= s-4 (R7); a taken branch redirects slot s+4 (R6).
  task automatic buildModel(int n);
    for (int i = 0; i < 32; i++) mreg[i] = '0;
    for (int i = 0; i < DW; i++) mmem[i] = dmemImg[i];
    for (int i = 0; i < MAXP; i++) redirV[i] = 1'b0;
    for (int s = 0; s < n; s++) begin
      logic [31:0] ins, a, b, imm, addr, res, pcS;
      logic [5:0] op, fn;
      logic [4:0] rs, rt, rd;
      if (s >= 4 && wbEnExp[s-4]) mreg[wbRegExp[s-4]] = wbDataExp[s-4];
      if (redirV[s]) pcS = redirPc[s];
      else if (s == 0) pcS = 32'd0;
      else pcS = pcExp[s-1] + 32'd4;
      pcExp[s] = pcS;
      pcTag[s] = redirV[s] ? "R6" : "R2";
      ins = imemImg[pcS[IAW+1:2]];
      op = ins[31:26]; rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11]; fn = ins[5:0];
      imm = {{16{ins[15]}}, ins[15:0]};
      a = (rs == 0) ? 32'd0 : mreg[rs];
      b = (rt == 0) ? 32'd0 : mreg[rt];
      addr = a + imm;
      wbEnExp[s] = 1'b0; wbRegExp[s] = '0; wbDataExp[s] = '0; tagExp[s] = "R9";
      case (op)
        6'h23: begin
          tagExp[s] = (rt == 0) ? "R8" : "R4 R10";
          wbEnExp[s] = (rt != 0); wbRegExp[s] = rt; wbDataExp[s] = mmem[addr[DAW+1:2]];
        end
        6'h2B: begin
          tagExp[s] = "R5";
          mmem[addr[DAW+1:2]] = b;
        end
        6'h04: begin
          tagExp[s] = "R6";
          if (a == b && s + 4 < MAXP) begin
            redirV[s+4] = 1'b1;
            redirPc[s+4] = pcS + 32'd4 + {imm[29:0], 2'b00};
          end
        end
        6'h00: begin
          case (fn)
            6'h20: res = a + b;
            6'h22: res = a - b;
            6'h24: res = a & b;
            6'h25: res = a | b;
            6'h2A: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            default: res = 'x;
          endcase
          if (fn == 6'h20 || fn == 6'h22 || fn == 6'h24 || fn == 6'h25 || fn == 6'h2A) begin
            tagExp[s] = (rd == 0) ? "R8" : "R3 R7";
            wbEnExp[s] = (rd != 0); wbRegExp[s] = rd; wbDataExp[s] = res;
          end
        end
        default: tagExp[s] = "R9";
      endcase
    end
  endtask

  task automatic runProg(int n);
    rst = 1'b1;
    @(negedge clk);
    for (int i = 0; i < IW; i++) begin
      loadEn = 1'b1; loadToData = 1'b0; loadAddr = LAW'(i); loadWord = imemImg[i];
      @(negedge clk);
    end
    for (int i = 0; i < DW; i++) begin
      loadEn = 1'b1; loadToData = 1'b1; loadAddr = LAW'(i); loadWord = dmemImg[i];
      @(negedge clk);
    end
    loadEn = 1'b0;
    @(negedge clk);
    check("R1", "pc in reset", dbgPc, 32'd0);
    check("R1", "wb enable in reset", {31'd0, dbgWbEn}, 32'd0);
    buildModel(n);
    rst = 1'b0;
    for (int p = 0; p < n; p++) begin
      if (p > 0) @(negedge clk);
      check(pcTag[p], "fetch address", dbgPc, pcExp[p]);
      if (p < 4) begin
        check("R1", "wb enable after reset", {31'd0, dbgWbEn}, 32'd0);
      end else begin
        check(tagExp[p-4], "wb enable", {31'd0, dbgWbEn}, {31'd0, wbEnExp[p-4]});
        if (wbEnExp[p-4]) begin
          check(tagExp[p-4], "wb register", {27'd0, dbgWbReg}, {27'd0, wbRegExp[p-4]});
          check(tagExp[p-4], "wb data", dbgWbData, wbDataExp[p-4]);
        end
      end
    end
  endtask

  function automatic logic [31:0] randInstr();
    logic [4:0] rs, rt, rd;
    int k;
    logic [5:0] fns [6];
    fns[0] = 6'h20; fns[1] = 6'h22; fns[2] = 6'h24; fns[3] = 6'h25; fns[4] = 6'h2A; fns[5] = 6'h21;
    k  = $urandom_range(0, 99);
    rs = 5'($urandom_range(0, 7));
    rt = 5'($urandom_range(0, 7));
    rd = 5'($urandom_range(0, 7));
    if (k < 40) return encR(fns[$urandom_range(0, 5)], rs, rt, rd);
    if (k < 60) return encI(6'h23, rs, rt, 16'($urandom_range(0, 63) * 4));
    if (k < 75) return encI(6'h2B, rs, rt, 16'($urandom_range(0, 63) * 4));
    if (k < 88) return encI(6'h04, rs, rt, 16'($signed($urandom_range(0, 12)) - 6));
    return encI(6'h0F, rs, rt, 16'($urandom));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired before the run completed");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < DW; i++) dmemImg[i] = 32'h1000_0000 + 32'(i * 7);

    // Directed program: load visibility (R7), slt signed (R3), r0 (R8),
    // store/load ordering (R5), taken branch with delay slots (R6), junk (R9)
    for (int i = 0; i < IW; i++) imemImg[i] = 32'd0;
    imemImg[0]  = encI(6'h23, 5'd0, 5'd1, 16'd8);
    imemImg[1]  = encR(6'h20, 5'd1, 5'd1, 5'd2);
    imemImg[2]  = encR(6'h20, 5'd1, 5'd1, 5'd3);
    imemImg[3]  = encR(6'h20, 5'd1, 5'd1, 5'd4);
    imemImg[4]  = encR(6'h20, 5'd1, 5'd1, 5'd5);
    imemImg[5]  = encR(6'h22, 5'd0, 5'd1, 5'd6);
    imemImg[6]  = encI(6'h23, 5'd0, 5'd0, 16'd4);
    imemImg[7]  = encR(6'h25, 5'd1, 5'd1, 5'd0);
    imemImg[8]  = encR(6'h2A, 5'd6, 5'd1, 5'd7);
    imemImg[9]  = encI(6'h2B, 5'd0, 5'd5, 16'd12);
    imemImg[10] = encI(6'h23, 5'd0, 5'd8, 16'd12);
    imemImg[11] = encI(6'h04, 5'd0, 5'd0, 16'd5);
    imemImg[12] = encR(6'h24, 5'd1, 5'd5, 5'd10);
    imemImg[13] = encR(6'h20, 5'd8, 5'd0, 5'd11);
    imemImg[14] = encR(6'h2A, 5'd1, 5'd6, 5'd12);
    imemImg[15] = encR(6'h20, 5'd1, 5'd1, 5'd20);
    imemImg[16] = encR(6'h20, 5'd1, 5'd1, 5'd21);
    imemImg[17] = encI(6'h3F, 5'd1, 5'd13, 16'h1234);
    imemImg[18] = encI(6'h04, 5'd1, 5'd0, 16'hFFF0);
    imemImg[19] = encR(6'h21, 5'd1, 5'd1, 5'd14);
    imemImg[20] = encR(6'h20, 5'd13, 5'd14, 5'd15);
    runProg(40);

    // Directed: branch in a delay slot of another taken branch, backward loop
    for (int i = 0; i < IW; i++) imemImg[i] = 32'd0;
    imemImg[0] = encI(6'h04, 5'd0, 5'd0, 16'd9);
    imemImg[1] = encI(6'h04, 5'd0, 5'd0, 16'hFFFE);
    imemImg[2] = encI(6'h23, 5'd0, 5'd3, 16'd0);
    imemImg[3] = encR(6'h20, 5'd3, 5'd3, 5'd4);
    imemImg[10] = encR(6'h20, 5'd3, 5'd3, 5'd5);
    runProg(30);

    // Random programs
    for (int t = 0; t < 8; t++) begin
      for (int i = 0; i < DW; i++) dmemImg[i] = $urandom;
      for (int i = 0; i < IW; i++) imemImg[i] = (i < 48) ? randInstr() : 32'd0;
      runProg(160);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule